// File: doc/BRIEF.md
# Four-Channel Serial DMA Transfer Engine

This block moves data between memory and I/O for four independent channels. Every transfer is two separate bus cycles. The first cycle reads one word from the source side into an internal holding register. The second cycle writes that word to the destination side. The holding register has no host access path.

Each channel is loaded through a small configuration port. A load sets the channel's start memory address, its I/O address, its transfer count and its operation. After a load, the channel serves its request line. When the engine finds an eligible channel, it raises `bus_req`. It starts a transfer only in a cycle where `grant` is high. After the last transfer, a per-channel terminal-count pulse fires and the channel's done flag rises. The channel then stays idle until it is loaded again.

The bus port is one master port with a 24-bit address, a memory/I/O select, read and write strobes, and write data. The slave returns read data and an acknowledge. The slave may hold a phase for any number of cycles by keeping `bus_ack` low.

Top module: `dma_serial_engine`

## Requirements
- R1: Each data transfer is a read bus cycle followed by a separate write bus cycle. The write cycle drives exactly the data returned in the preceding read cycle.
- R2: A channel loaded with count N performs N+1 transfers. Count 0 gives exactly one transfer.
- R3: The memory address is 24 bits wide. It starts at the loaded value and moves by one after each transfer: down when `cfg_down` is 1, up when it is 0.
- R4: In every I/O-side bus cycle (`bus_mio`=0), `bus_addr` carries the channel's 16-bit I/O address, zero-extended, when `cfg_io_en` was 1 at load. When `cfg_io_en` was 0, `bus_addr` is 24'h000000. The I/O address never changes during the transfers.
- R5: `cfg_op` selects the direction:
  - 2'b01: I/O read, then memory write.
  - 2'b10: memory read, then I/O write.
  - 2'b00 (verify): one memory read per transfer and no write.
- R6: A channel loaded with `cfg_op`=2'b11 never starts: no bus cycle, no terminal count, no done.
- R7: A channel whose `mask` bit is 1 starts no transfer and causes no `bus_req` while it waits. It proceeds once the mask bit is cleared.
- R8: After a channel's last transfer, `tc[ch]` is 1 for exactly one clock and `done[ch]` goes to 1. Further requests on that channel cause no bus cycle until the next load, and the load clears `done[ch]`.
- R9: When several channels are eligible, the lowest-numbered one is started first.
- R10: A transfer starts only in a cycle with `grant`=1. `bus_rd` and `bus_wr` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load strobe for channel `cfg_ch` |
| cfg_ch | input | 2 | Channel being loaded |
| cfg_mem_addr | input | 24 | Start memory address |
| cfg_io_addr | input | 16 | I/O address for the I/O phase |
| cfg_count | input | 16 | Transfer count (transfers = count + 1) |
| cfg_op | input | 2 | Operation: 00 verify, 01 I/O to memory, 10 memory to I/O, 11 none |
| cfg_down | input | 1 | 1 = memory address decrements |
| cfg_io_en | input | 1 | 1 = drive the I/O address, 0 = drive zero |
| req | input | 4 | Per-channel request lines |
| mask | input | 4 | Per-channel disable bits |
| grant | input | 1 | Bus grant from the external arbiter |
| bus_req | output | 1 | Engine wants or holds the bus |
| bus_addr | output | 24 | Bus address |
| bus_mio | output | 1 | 1 = memory cycle, 0 = I/O cycle |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | 16 | Write data from the holding register |
| bus_rdata | input | 16 | Read data from the slave |
| bus_ack | input | 1 | Slave completes the current phase |
| tc | output | 4 | One-clock terminal-count pulse per channel |
| done | output | 4 | Per-channel finished flag, cleared by a load |

## Verification
The bound checker watches four properties on every cycle:
- the read and write strobes never overlap;
- a transfer never starts without grant, on a masked channel, or on a channel holding the unused operation code;
- every write carries the last word read;
- I/O-phase addresses are zero whenever the selected channel has the I/O address disabled, and terminal-count pulses are single-cycle and single-channel.

Other properties depend on history, so only the bench's directed scenarios can show them:
- the number of transfers against the count;
- the direction of address stepping;
- the phase order for each operation;
- the lowest-index ordering between competing channels;
- the fact that a finished channel ignores its request until it is reloaded.

// File: rtl/dma_serial_pkg.sv
package dma_serial_pkg;
  typedef enum logic [1:0] {
    OP_VERIFY = 2'b00,
    OP_IO2MEM = 2'b01,
    OP_MEM2IO = 2'b10,
    OP_NONE   = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_SRC  = 2'b01,
    ST_DST  = 2'b10
  } phase_e;

  // Source side is memory for verify and memory-to-I/O.
  function automatic logic src_is_mem(input op_e op);
    return op != OP_IO2MEM;
  endfunction
endpackage

// File: rtl/dma_chan_slot.sv
module dma_chan_slot
  import dma_serial_pkg::*;
#(
  parameter int AW  = 24,
  parameter int IOW = 16,
  parameter int CW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [AW-1:0]  ld_addr,
  input  logic [IOW-1:0] ld_io,
  input  logic [CW-1:0]  ld_cnt,
  input  op_e            ld_op,
  input  logic           ld_down,
  input  logic           ld_io_en,
  input  logic           adv,
  output logic [AW-1:0]  addr_o,
  output logic [IOW-1:0] io_o,
  output op_e            op_o,
  output logic           io_en_o,
  output logic           last_o,
  output logic           armed_o,
  output logic           done_o
);
  logic [CW-1:0] cnt_q;
  logic          down_q;

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a, input logic dn);
    return dn ? a - AW'(1) : a + AW'(1);
  endfunction

  assign last_o = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_o  <= '0;
      io_o    <= '0;
      cnt_q   <= '0;
      op_o    <= OP_NONE;
      down_q  <= 1'b0;
      io_en_o <= 1'b0;
      armed_o <= 1'b0;
      done_o  <= 1'b0;
    end else if (load) begin
      addr_o  <= ld_addr;
      io_o    <= ld_io;
      cnt_q   <= ld_cnt;
      op_o    <= ld_op;
      down_q  <= ld_down;
      io_en_o <= ld_io_en;
      armed_o <= (ld_op != OP_NONE);
      done_o  <= 1'b0;
    end else if (adv) begin
      addr_o <= step_addr(addr_o, down_q);
      cnt_q  <= cnt_q - CW'(1);
      if (last_o) begin
        armed_o <= 1'b0;
        done_o  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_prio.sv
module dma_prio #(
  parameter int NCH = 4,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] elig,
  output logic           any,
  output logic [IW-1:0]  idx
);
  always_comb begin
    any = |elig;
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (elig[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/dma_phase_seq.sv
module dma_phase_seq
  import dma_serial_pkg::*;
#(
  parameter int AW  = 24,
  parameter int IOW = 16,
  parameter int DW  = 16,
  parameter int IW  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           any,
  input  logic [IW-1:0]  pick_idx,
  input  logic           grant,
  input  op_e            op,
  input  logic [AW-1:0]  mem_addr,
  input  logic [IOW-1:0] io_addr,
  input  logic           io_en,
  input  logic           bus_ack,
  input  logic [DW-1:0]  bus_rdata,
  output logic [IW-1:0]  sel_idx,
  output logic           start,
  output logic           step,
  output logic           bus_req,
  output logic [AW-1:0]  bus_addr,
  output logic           bus_mio,
  output logic           bus_rd,
  output logic           bus_wr,
  output logic [DW-1:0]  bus_wdata
);
  phase_e        st_q;
  logic [DW-1:0] hold_q;
  logic [AW-1:0] io_phase_addr;
  logic          mem_src;

  assign mem_src       = src_is_mem(op);
  assign io_phase_addr = io_en ? {{(AW-IOW){1'b0}}, io_addr} : '0;
  assign start         = (st_q == ST_IDLE) && any && grant;
  assign step          = bus_ack && (((st_q == ST_SRC) && (op == OP_VERIFY)) || (st_q == ST_DST));
  assign bus_req       = any || (st_q != ST_IDLE);
  assign bus_wdata     = hold_q;

  always_comb begin
    bus_rd   = 1'b0;
    bus_wr   = 1'b0;
    bus_mio  = 1'b0;
    bus_addr = '0;
    case (st_q)
      ST_SRC: begin
        bus_rd   = 1'b1;
        bus_mio  = mem_src;
        bus_addr = mem_src ? mem_addr : io_phase_addr;
      end
      ST_DST: begin
        bus_wr   = 1'b1;
        bus_mio  = !mem_src;
        bus_addr = mem_src ? io_phase_addr : mem_addr;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      sel_idx <= '0;
      hold_q  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          sel_idx <= pick_idx;
          st_q    <= ST_SRC;
        end
        ST_SRC: if (bus_ack) begin
          hold_q <= bus_rdata;
          st_q   <= (op == OP_VERIFY) ? ST_IDLE : ST_DST;
        end
        ST_DST: if (bus_ack) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_serial_engine.sv
module dma_serial_engine
  import dma_serial_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 24,
  parameter int IOW = 16,
  parameter int DW  = 16,
  parameter int CW  = 16,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [IW-1:0]  cfg_ch,
  input  logic [AW-1:0]  cfg_mem_addr,
  input  logic [IOW-1:0] cfg_io_addr,
  input  logic [CW-1:0]  cfg_count,
  input  logic [1:0]     cfg_op,
  input  logic           cfg_down,
  input  logic           cfg_io_en,
  input  logic [NCH-1:0] req,
  input  logic [NCH-1:0] mask,
  input  logic           grant,
  output logic           bus_req,
  output logic [AW-1:0]  bus_addr,
  output logic           bus_mio,
  output logic           bus_rd,
  output logic           bus_wr,
  output logic [DW-1:0]  bus_wdata,
  input  logic [DW-1:0]  bus_rdata,
  input  logic           bus_ack,
  output logic [NCH-1:0] tc,
  output logic [NCH-1:0] done
);
  logic [AW-1:0]  ch_addr  [NCH];
  logic [IOW-1:0] ch_io    [NCH];
  op_e            ch_op    [NCH];
  logic [NCH-1:0] ch_io_en, ch_last, ch_armed, elig, adv;
  logic           any, start, step;
  logic [IW-1:0]  pick_idx, sel_idx;
  op_e            start_op;
  logic           sel_io_en;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign elig[i] = req[i] && ch_armed[i] && !mask[i];
    assign adv[i]  = step && (sel_idx == IW'(i));
    dma_chan_slot #(.AW(AW), .IOW(IOW), .CW(CW)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .load(cfg_we && (cfg_ch == IW'(i))),
      .ld_addr(cfg_mem_addr), .ld_io(cfg_io_addr), .ld_cnt(cfg_count),
      .ld_op(op_e'(cfg_op)), .ld_down(cfg_down), .ld_io_en(cfg_io_en),
      .adv(adv[i]),
      .addr_o(ch_addr[i]), .io_o(ch_io[i]), .op_o(ch_op[i]),
      .io_en_o(ch_io_en[i]), .last_o(ch_last[i]),
      .armed_o(ch_armed[i]), .done_o(done[i])
    );
  end

  dma_prio #(.NCH(NCH)) u_prio (.elig(elig), .any(any), .idx(pick_idx));

  assign start_op  = ch_op[pick_idx];
  assign sel_io_en = ch_io_en[sel_idx];

  dma_phase_seq #(.AW(AW), .IOW(IOW), .DW(DW), .IW(IW)) u_seq (
    .clk(clk), .rst_n(rst_n), .any(any), .pick_idx(pick_idx), .grant(grant),
    .op(ch_op[sel_idx]), .mem_addr(ch_addr[sel_idx]), .io_addr(ch_io[sel_idx]),
    .io_en(sel_io_en), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .sel_idx(sel_idx), .start(start), .step(step), .bus_req(bus_req),
    .bus_addr(bus_addr), .bus_mio(bus_mio), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tc <= '0;
    else        tc <= (step && ch_last[sel_idx]) ? ({{(NCH-1){1'b0}}, 1'b1} << sel_idx) : '0;
  end
endmodule

// File: rtl/dma_serial_engine_chk.sv
module dma_serial_engine_chk #(
  parameter int NCH = 4,
  parameter int AW  = 24,
  parameter int DW  = 16,
  parameter int IW  = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           grant,
  input logic [NCH-1:0] mask,
  input logic           start,
  input logic [IW-1:0]  pick_idx,
  input logic [1:0]     start_op,
  input logic           sel_io_en,
  input logic [AW-1:0]  bus_addr,
  input logic           bus_mio,
  input logic           bus_rd,
  input logic           bus_wr,
  input logic [DW-1:0]  bus_wdata,
  input logic [DW-1:0]  bus_rdata,
  input logic           bus_ack,
  input logic [NCH-1:0] tc
);
  logic [DW-1:0] seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else if (bus_rd && bus_ack) seen_q <= bus_rdata;
  end

  assert_wdata_from_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> (bus_wdata == seen_q));
  assert_io_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rd || bus_wr) && !bus_mio && !sel_io_en) |-> (bus_addr == '0));
  assert_no_reserved_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (start_op != 2'b11));
  assert_no_masked_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !mask[pick_idx]);
  assert_tc_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tc));
  assert_tc_one_clock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|tc) |=> ((tc & $past(tc)) == '0));
  assert_start_needs_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> grant);
  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));
endmodule

bind dma_serial_engine dma_serial_engine_chk #(.NCH(NCH), .AW(AW), .DW(DW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .grant(grant), .mask(mask), .start(start),
  .pick_idx(pick_idx), .start_op(start_op), .sel_io_en(sel_io_en),
  .bus_addr(bus_addr), .bus_mio(bus_mio), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack), .tc(tc)
);

// File: tb/dma_serial_engine_tb.sv
module dma_serial_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_ch = '0;
  logic [23:0] cfg_mem_addr = '0;
  logic [15:0] cfg_io_addr = '0;
  logic [15:0] cfg_count = '0;
  logic [1:0]  cfg_op = '0;
  logic        cfg_down = 1'b0;
  logic        cfg_io_en = 1'b0;
  logic [3:0]  req = '0;
  logic [3:0]  mask = '0;
  logic        grant = 1'b1;
  logic        bus_req, bus_mio, bus_rd, bus_wr, bus_ack;
  logic [23:0] bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic [3:0]  tc, done;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  dma_serial_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
    .cfg_mem_addr(cfg_mem_addr), .cfg_io_addr(cfg_io_addr), .cfg_count(cfg_count),
    .cfg_op(cfg_op), .cfg_down(cfg_down), .cfg_io_en(cfg_io_en),
    .req(req), .mask(mask), .grant(grant), .bus_req(bus_req), .bus_addr(bus_addr),
    .bus_mio(bus_mio), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .tc(tc), .done(done)
  );

  function automatic logic [15:0] mem_val(input logic [23:0] a);
    return a[15:0] ^ 16'h5A5A;
  endfunction
  function automatic logic [15:0] io_val(input logic [23:0] a);
    return a[15:0] ^ 16'hC3C3;
  endfunction

  assign bus_ack   = bus_rd | bus_wr;
  assign bus_rdata = bus_mio ? mem_val(bus_addr) : io_val(bus_addr);

  logic [23:0] rd_a [64];
  logic        rd_m [64];
  logic [23:0] wr_a [64];
  logic        wr_m [64];
  logic [15:0] wr_d [64];
  int n_rd = 0, n_wr = 0, n_cyc = 0;
  int tc_cnt [4] = '{0, 0, 0, 0};
  int tc_long = 0;
  logic [3:0] tc_prev = '0;

  always @(posedge clk) begin
    n_cyc <= n_cyc + 1;
    if (bus_rd) begin
      rd_a[n_rd % 64] <= bus_addr; rd_m[n_rd % 64] <= bus_mio; n_rd <= n_rd + 1;
    end
    if (bus_wr) begin
      wr_a[n_wr % 64] <= bus_addr; wr_m[n_wr % 64] <= bus_mio;
      wr_d[n_wr % 64] <= bus_wdata; n_wr <= n_wr + 1;
    end
    for (int i = 0; i < 4; i++) if (tc[i]) tc_cnt[i] <= tc_cnt[i] + 1;
    if ((tc & tc_prev) != 0) tc_long <= tc_long + 1;
    tc_prev <= tc;
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic load(input int ch, input logic [23:0] a, input logic [15:0] io,
                      input logic [15:0] cnt, input logic [1:0] op, input bit dn, input bit ioen);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_mem_addr = a; cfg_io_addr = io;
    cfg_count = cnt; cfg_op = op; cfg_down = dn; cfg_io_en = ioen;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_done(input int ch, input string rq);
    int n = 0;
    while (!done[ch] && n < 500) begin @(negedge clk); n++; end
    chk(done[ch] == 1'b1, rq, 32'(done[ch]), 32'd1);
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(bus_req == 0 && bus_rd == 0 && bus_wr == 0, "R10 reset bus", {bus_req, bus_rd, bus_wr}, 0);
    chk(tc == 0 && done == 0, "R8 reset flags", {tc, done}, 0);
  endtask

  task automatic t_mem_to_io();
    int r0 = n_rd, w0 = n_wr, t0 = tc_cnt[0];
    load(0, 24'h012340, 16'h0300, 16'd2, 2'b10, 1'b0, 1'b1);
    req[0] = 1'b1;
    wait_done(0, "R8 done ch0");
    idle_cycles(2);
    chk(n_wr - w0 == 3, "R2 count 2 gives 3", n_wr - w0, 3);
    chk(n_rd - r0 == 3, "R1 reads per transfer", n_rd - r0, 3);
    for (int k = 0; k < 3; k++) begin
      chk(rd_m[(r0+k)%64] == 1 && rd_a[(r0+k)%64] == 24'h012340 + 24'(k), "R3 R5 mem read addr up",
          rd_a[(r0+k)%64], 24'h012340 + 24'(k));
      chk(wr_m[(w0+k)%64] == 0 && wr_a[(w0+k)%64] == 24'h000300, "R4 io write addr",
          wr_a[(w0+k)%64], 24'h000300);
      chk(wr_d[(w0+k)%64] == mem_val(24'h012340 + 24'(k)), "R1 data carried",
          wr_d[(w0+k)%64], mem_val(24'h012340 + 24'(k)));
    end
    chk(tc_cnt[0] - t0 == 1, "R8 one tc pulse", tc_cnt[0] - t0, 1);
    // finished channel: request still high, no new bus cycles
    r0 = n_rd;
    idle_cycles(30);
    chk(n_rd == r0 && bus_req == 0, "R8 ignored after done", n_rd - r0, 0);
    // reload clears done and runs again
    load(0, 24'h000100, 16'h0300, 16'd0, 2'b10, 1'b0, 1'b1);
    chk(done[0] == 0, "R8 load clears done", done[0], 0);
    wait_done(0, "R8 rerun after load");
    req[0] = 1'b0;
    idle_cycles(2);
    chk(n_rd - r0 == 1, "R8 rerun one transfer", n_rd - r0, 1);
  endtask

  task automatic t_io_to_mem_down();
    int r0 = n_rd, w0 = n_wr;
    load(1, 24'h000001, 16'h1234, 16'd1, 2'b01, 1'b1, 1'b0);
    req[1] = 1'b1;
    wait_done(1, "R8 done ch1");
    req[1] = 1'b0;
    idle_cycles(2);
    chk(n_wr - w0 == 2, "R2 count 1 gives 2", n_wr - w0, 2);
    for (int k = 0; k < 2; k++) begin
      chk(rd_m[(r0+k)%64] == 0 && rd_a[(r0+k)%64] == 24'h0, "R4 forced zero io addr",
          rd_a[(r0+k)%64], 0);
      chk(wr_m[(w0+k)%64] == 1 && wr_a[(w0+k)%64] == 24'h000001 - 24'(k), "R3 R5 mem write addr down",
          wr_a[(w0+k)%64], 24'h000001 - 24'(k));
      chk(wr_d[(w0+k)%64] == io_val(24'h0), "R1 io data to mem", wr_d[(w0+k)%64], io_val(24'h0));
    end
  endtask

  task automatic t_count_zero();
    int w0 = n_wr;
    load(2, 24'hABCDEF, 16'h0055, 16'd0, 2'b10, 1'b0, 1'b1);
    req[2] = 1'b1;
    wait_done(2, "R2 done count 0");
    req[2] = 1'b0;
    idle_cycles(2);
    chk(n_wr - w0 == 1, "R2 count 0 one transfer", n_wr - w0, 1);
    chk(wr_a[w0%64] == 24'h000055, "R4 io addr enabled", wr_a[w0%64], 24'h000055);
  endtask

  task automatic t_verify();
    int r0 = n_rd, w0 = n_wr;
    load(3, 24'h00F000, 16'h0000, 16'd3, 2'b00, 1'b0, 1'b0);
    req[3] = 1'b1;
    wait_done(3, "R5 verify done");
    req[3] = 1'b0;
    idle_cycles(2);
    chk(n_rd - r0 == 4 && n_wr == w0, "R5 verify reads only", {16'(n_rd - r0), 16'(n_wr - w0)}, {16'd4, 16'd0});
    chk(rd_m[(r0+3)%64] == 1 && rd_a[(r0+3)%64] == 24'h00F003, "R3 verify addr",
        rd_a[(r0+3)%64], 24'h00F003);
  endtask

  task automatic t_mask();
    int r0 = n_rd;
    mask[2] = 1'b1;
    load(2, 24'h000200, 16'h0077, 16'd1, 2'b10, 1'b0, 1'b1);
    req[2] = 1'b1;
    idle_cycles(30);
    chk(n_rd == r0 && bus_req == 0 && done[2] == 0, "R7 masked no cycles",
        {bus_req, done[2], 30'(n_rd - r0)}, 0);
    mask[2] = 1'b0;
    wait_done(2, "R7 runs after unmask");
    req[2] = 1'b0;
    idle_cycles(2);
    chk(n_rd - r0 == 2, "R7 transfers after unmask", n_rd - r0, 2);
  endtask

  task automatic t_reserved();
    int r0 = n_rd, t0 = tc_cnt[3];
    load(3, 24'h000300, 16'h0001, 16'd0, 2'b11, 1'b0, 1'b1);
    req[3] = 1'b1;
    idle_cycles(30);
    chk(n_rd == r0 && bus_req == 0, "R6 op 11 no cycles", n_rd - r0, 0);
    chk(done[3] == 0 && tc_cnt[3] == t0, "R6 op 11 no done", {done[3], 31'(tc_cnt[3] - t0)}, 0);
    req[3] = 1'b0;
  endtask

  task automatic t_grant_and_prio();
    int w0 = n_wr;
    grant = 1'b0;
    load(1, 24'h000010, 16'h0011, 16'd0, 2'b10, 1'b0, 1'b1);
    load(0, 24'h000020, 16'h0010, 16'd0, 2'b10, 1'b0, 1'b1);
    req[1] = 1'b1; req[0] = 1'b1;
    idle_cycles(20);
    chk(n_wr == w0 && bus_req == 1, "R10 wait for grant", {bus_req, 31'(n_wr - w0)}, 32'h80000000);
    grant = 1'b1;
    wait_done(0, "R9 ch0 done");
    wait_done(1, "R9 ch1 done");
    req = '0;
    idle_cycles(2);
    chk(wr_a[w0%64] == 24'h000010, "R9 lowest index first", wr_a[w0%64], 24'h000010);
    chk(wr_a[(w0+1)%64] == 24'h000011, "R9 next channel second", wr_a[(w0+1)%64], 24'h000011);
    chk(tc_long == 0, "R8 tc single clock", tc_long, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mem_to_io();
    t_io_to_mem_down();
    t_count_zero();
    t_verify();
    t_mask();
    t_reserved();
    t_grant_and_prio();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule